// File: doc/BRIEF.md
# Serial ADC Host Conversion Controller

This block sits on the host side of a 16-bit successive-approximation converter that has a conversion-start line and a full-duplex serial link. When a request arrives, the controller raises the convert line and holds it high for a fixed conversion wait. It then drops the line, allows a short lead gap, and runs one serial frame of exactly sixteen clock periods. In that frame a 14-bit configuration word goes out MSB first on the host-to-converter data line, and the 16-bit conversion result comes back MSB first.

The finished result appears with a one-cycle valid strobe. It is given both as the raw code and as a 17-bit value that is zero-extended when unipolar or sign-extended when bipolar. The configuration word that was in force for the frame is returned with it. Requests that arrive while a conversion is running, or before the minimum spacing between conversion starts has passed, are held and launched as soon as both conditions clear. Several held requests merge into one launch, which takes the most recent settings.

The serial clock is derived from the system clock through a half-period divider. All timing windows (conversion wait, lead gap, minimum start spacing) are counted in system-clock cycles and set by parameters.

Top module: `adc_conv_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no request, the convert line, serial clock, outgoing data line and valid strobe are all low.
- R2: A request sampled while the controller is idle and the start spacing has already elapsed makes the convert line rise on the next clock edge.
- R3: The convert line stays high for exactly CONV_CYC cycles per conversion, and the serial clock stays low for that whole time.
- R4: The first serial clock rising edge comes LEAD_CYC + SCK_HALF cycles after the convert line falls. Every serial clock high phase and low phase lasts SCK_HALF cycles, and each frame has exactly 16 rising edges.
- R5: The outgoing data line carries the 14 configuration bits MSB first, one per serial clock period, across the first 14 periods, and is low during periods 15 and 16. It changes only at serial clock falling edges.
- R6: The incoming data line is sampled on each of the 16 serial clock falling edges, and the samples are assembled MSB first into res_data_o.
- R7: res_valid_o is high for exactly one cycle, CONV_CYC + LEAD_CYC + 32*SCK_HALF cycles after the convert line rose.
- R8: When the request's mode flag was 1 (bipolar), res_value_o is res_data_o sign-extended to 17 bits. When it was 0, res_value_o is res_data_o zero-extended. res_cfg_o carries the configuration word sent in that frame.
- R9: Convert line rising edges are at least MIN_CYC cycles apart. A request held back by a running conversion or by the spacing launches in the first cycle where the controller is idle and MIN_CYC cycles have passed since the previous rise.
- R10: Several requests that arrive before a launch produce exactly one conversion, and it uses the configuration and mode of the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, sampled each cycle |
| cfg_i | input | 14 | Configuration word captured with the request |
| bipolar_i | input | 1 | Mode flag captured with the request: 1 selects two's-complement interpretation |
| cnv_o | output | 1 | Convert line to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| sdi_o | output | 1 | Serial data to the converter (configuration bits) |
| sdo_i | input | 1 | Serial data from the converter (result bits) |
| res_valid_o | output | 1 | One-cycle strobe marking a new result |
| res_data_o | output | 16 | Raw result code |
| res_value_o | output | 17 | Result extended according to the mode flag |
| res_cfg_o | output | 14 | Configuration word that was in force for this result |

## Verification
The embedded assertions check on every cycle that the serial clock never runs while the convert line is high, that the convert line holds for the whole wait, that the valid strobe never lasts two cycles, that launches never fall on adjacent cycles, that a held request is not lost, and that the two tail bits of the frame drive the data line low. Exact cycle counts cannot be seen from those local checks: the conversion width, the lead gap, the serial clock phase widths, the start-to-result latency, and the launch cycle when spacing, busy time and request timing compete. The same holds for the bit order of the configuration and result and the merging of several held requests. Only the bench's converter model and its scenarios show these.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  parameter int unsigned ADC_RES_W = 16;
  parameter int unsigned ADC_CFG_W = 14;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_LEAD  = 2'd2,
    ST_FRAME = 2'd3
  } ctrl_state_t;

  // Extends a raw code by one bit; the sign bit is copied only in two's-complement mode.
  function automatic logic [ADC_RES_W:0] widen_result(input logic [ADC_RES_W-1:0] raw,
                                                      input logic twos);
    widen_result = {twos & raw[ADC_RES_W-1], raw};
  endfunction

  // Number of bits needed to count 0..n inclusive.
  function automatic int unsigned cnt_width(input int unsigned n);
    cnt_width = (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/adc_start_gate.sv
module adc_start_gate #(
  parameter int unsigned MIN_CYC = 400,
  parameter int unsigned CFG_W   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             bip_i,
  input  logic             idle_i,
  output logic             launch_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             bip_o
);
  localparam int unsigned GW = adc_ctrl_pkg::cnt_width(MIN_CYC);

  logic [GW-1:0]    since_q;
  logic             pend_q;
  logic [CFG_W-1:0] cfg_q;
  logic             bip_q;
  logic             gap_met;

  assign gap_met  = (since_q >= GW'(MIN_CYC));
  assign launch_o = idle_i && gap_met && pend_q;
  assign cfg_o    = cfg_q;
  assign bip_o    = bip_q;

  // Spacing counter: cycles since the last launch, saturating at the limit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= GW'(MIN_CYC);
    end else if (launch_o) begin
      since_q <= GW'(1);
    end else if (!gap_met) begin
      since_q <= since_q + GW'(1);
    end
  end

  // Held request: the newest settings overwrite older ones until launch.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cfg_q  <= '0;
      bip_q  <= 1'b0;
    end else if (req_i) begin
      pend_q <= 1'b1;
      cfg_q  <= cfg_i;
      bip_q  <= bip_i;
    end else if (launch_o) begin
      pend_q <= 1'b0;
    end
  end

  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !launch_o) |=> pend_q); // R9
  AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |=> !launch_o); // R9

endmodule

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
  parameter int unsigned SCK_HALF = 1,
  parameter int unsigned NBITS    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_i,
  output logic                     sck_o,
  output logic                     fall_o,
  output logic                     last_o,
  output logic [$clog2(NBITS)-1:0] bit_o
);
  localparam int unsigned PW = adc_ctrl_pkg::cnt_width(2 * SCK_HALF - 1);
  localparam int unsigned BW = $clog2(NBITS);

  logic [PW-1:0] ph_q;
  logic [BW-1:0] bit_q;
  logic          sck_q;

  assign fall_o = run_i && (ph_q == PW'(2 * SCK_HALF - 1));
  assign last_o = fall_o && (bit_q == BW'(NBITS - 1));
  assign sck_o  = sck_q;
  assign bit_o  = bit_q;

  // Low half first, then high half; the period ends on the falling edge.
  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      ph_q  <= '0;
      bit_q <= '0;
      sck_q <= 1'b0;
    end else if (fall_o) begin
      ph_q  <= '0;
      sck_q <= 1'b0;
      bit_q <= last_o ? '0 : bit_q + BW'(1);
    end else begin
      ph_q <= ph_q + PW'(1);
      if (ph_q == PW'(SCK_HALF - 1)) begin
        sck_q <= 1'b1;
      end
    end
  end

  AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !sck_o); // R4

endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
  parameter int unsigned CFG_W = 14,
  parameter int unsigned RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             fall_i,
  input  logic             sdo_i,
  output logic             sdi_o,
  output logic [RES_W-1:0] rx_next_o
);
  logic [CFG_W-1:0] tx_q;
  logic [RES_W-1:0] rx_q;

  // Zeros fill from the bottom, so the tail of the frame drives low.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (load_i) begin
      tx_q <= cfg_i;
    end else if (fall_i) begin
      tx_q <= {tx_q[CFG_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (fall_i) begin
      rx_q <= rx_next_o;
    end
  end

  assign sdi_o     = tx_q[CFG_W-1];
  assign rx_next_o = {rx_q[RES_W-2:0], sdo_i};

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned CONV_CYC = 220,
  parameter int unsigned MIN_CYC  = 400,
  parameter int unsigned LEAD_CYC = 1,
  parameter int unsigned SCK_HALF = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [ADC_CFG_W-1:0] cfg_i,
  input  logic                 bipolar_i,
  output logic                 cnv_o,
  output logic                 sck_o,
  output logic                 sdi_o,
  input  logic                 sdo_i,
  output logic                 res_valid_o,
  output logic [ADC_RES_W-1:0] res_data_o,
  output logic [ADC_RES_W:0]   res_value_o,
  output logic [ADC_CFG_W-1:0] res_cfg_o
);
  localparam int unsigned CFG_W = ADC_CFG_W;
  localparam int unsigned RES_W = ADC_RES_W;
  localparam int unsigned TMAX  = (CONV_CYC > LEAD_CYC) ? CONV_CYC : LEAD_CYC;
  localparam int unsigned TW    = cnt_width(TMAX);
  localparam int unsigned BW    = $clog2(RES_W);

  ctrl_state_t      state_q;
  logic [TW-1:0]    tmr_q;
  logic             cnv_q;
  logic [CFG_W-1:0] cfg_act_q;
  logic             bip_act_q;
  logic             valid_q;
  logic [RES_W-1:0] data_q;
  logic [CFG_W-1:0] rcfg_q;
  logic             rbip_q;

  // Named internal events
  logic             launch;
  logic [CFG_W-1:0] gate_cfg;
  logic             gate_bip;
  logic             frame_run;
  logic             sck_fall;
  logic             frame_last;
  logic [BW-1:0]    bit_idx;
  logic [RES_W-1:0] rx_next;

  adc_start_gate #(.MIN_CYC(MIN_CYC), .CFG_W(CFG_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (start_i),
    .cfg_i    (cfg_i),
    .bip_i    (bipolar_i),
    .idle_i   (state_q == ST_IDLE),
    .launch_o (launch),
    .cfg_o    (gate_cfg),
    .bip_o    (gate_bip)
  );

  assign frame_run = (state_q == ST_FRAME);

  adc_sck_gen #(.SCK_HALF(SCK_HALF), .NBITS(RES_W)) u_sck (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (frame_run),
    .sck_o  (sck_o),
    .fall_o (sck_fall),
    .last_o (frame_last),
    .bit_o  (bit_idx)
  );

  adc_frame_shifter #(.CFG_W(CFG_W), .RES_W(RES_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (launch),
    .cfg_i     (gate_cfg),
    .fall_i    (sck_fall),
    .sdo_i     (sdo_i),
    .sdi_o     (sdi_o),
    .rx_next_o (rx_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tmr_q     <= '0;
      cnv_q     <= 1'b0;
      cfg_act_q <= '0;
      bip_act_q <= 1'b0;
      valid_q   <= 1'b0;
      data_q    <= '0;
      rcfg_q    <= '0;
      rbip_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (launch) begin
            state_q   <= ST_CONV;
            cnv_q     <= 1'b1;
            tmr_q     <= '0;
            cfg_act_q <= gate_cfg;
            bip_act_q <= gate_bip;
          end
        end
        ST_CONV: begin
          if (tmr_q == TW'(CONV_CYC - 1)) begin
            state_q <= ST_LEAD;
            cnv_q   <= 1'b0;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + TW'(1);
          end
        end
        ST_LEAD: begin
          if (tmr_q == TW'(LEAD_CYC - 1)) begin
            state_q <= ST_FRAME;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + TW'(1);
          end
        end
        ST_FRAME: begin
          if (frame_last) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b1;
            data_q  <= rx_next;
            rcfg_q  <= cfg_act_q;
            rbip_q  <= bip_act_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_o       = cnv_q;
  assign res_valid_o = valid_q;
  assign res_data_o  = data_q;
  assign res_cfg_o   = rcfg_q;
  assign res_value_o = widen_result(data_q, rbip_q);

  AST_CNV_NO_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |-> !sck_o); // R3
  AST_CNV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV) |-> cnv_o); // R3
  AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o); // R7
  AST_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && (bit_idx >= BW'(CFG_W))) |-> !sdi_o); // R5

endmodule

// File: tb/adc_conv_ctrl_tb_top.sv
module adc_conv_ctrl_tb_top;
  localparam int C    = 30;
  localparam int L    = 2;
  localparam int H    = 2;
  localparam int MIN  = 120;
  localparam int NB   = 16;
  localparam int LAT  = C + L + 2 * H * NB;
  localparam int WDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [13:0] cfg_i;
  logic        bipolar_i;
  logic        cnv_o, sck_o, sdi_o, sdo_i;
  logic        res_valid_o;
  logic [15:0] res_data_o;
  logic [16:0] res_value_o;
  logic [13:0] res_cfg_o;

  always #5 clk = ~clk;

  adc_conv_ctrl #(.CONV_CYC(C), .MIN_CYC(MIN), .LEAD_CYC(L), .SCK_HALF(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i), .bipolar_i(bipolar_i),
    .cnv_o(cnv_o), .sck_o(sck_o), .sdi_o(sdi_o), .sdo_i(sdo_i),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o), .res_value_o(res_value_o),
    .res_cfg_o(res_cfg_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Model state: the held request and the converter's analog sample
  bit          m_pend = 0;
  int          m_first_req = 0;
  logic [13:0] m_cfg;
  logic        m_bip;
  logic [15:0] m_res;

  // Active conversion seen by the converter model
  logic [13:0] a_cfg;
  logic        a_bip;
  logic [15:0] a_res;
  logic [15:0] cap;
  int  rise_cnt = 0, valid_cnt = 0;
  int  last_rise = 0, last_valid = 0, cnv_fall = 0, last_srise = 0, last_sfall = 0;
  bit  have_rise = 0, have_valid = 0, want_low = 0;
  int  sck_rises = 0, bidx = 0;
  bit  frame_err = 0, cnv_sck_err = 0;
  logic p_cnv = 1'b0, p_sck = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cnv_o && !p_cnv) begin
        int exp_c;
        exp_c = m_first_req + 2;
        if (have_rise && last_rise + MIN > exp_c) exp_c = last_rise + MIN;
        if (have_valid && last_valid + 1 > exp_c) exp_c = last_valid + 1;
        check(cyc == exp_c, "R2 R9 launch cycle", cyc, exp_c);
        if (have_rise) check(cyc - last_rise >= MIN, "R9 start spacing", cyc - last_rise, MIN);
        last_rise = cyc; have_rise = 1; rise_cnt++;
        a_cfg = m_cfg; a_bip = m_bip; a_res = m_res; m_pend = 0;
        sck_rises = 0; frame_err = 0; cnv_sck_err = 0; cap = '0;
      end
      if (cnv_o && sck_o) cnv_sck_err = 1;
      if (!cnv_o && p_cnv) begin
        check(cyc - last_rise == C, "R3 convert width", cyc - last_rise, C);
        cnv_fall = cyc; bidx = 15; sdo_i = a_res[15];
      end
      if (sck_o && !p_sck) begin
        if (sck_rises == 0) begin
          if (cyc - cnv_fall != L + H) frame_err = 1;
        end else if (cyc - last_sfall != H) frame_err = 1;
        cap = {cap[14:0], sdi_o}; sck_rises++; last_srise = cyc;
      end
      if (!sck_o && p_sck) begin
        if (cyc - last_srise != H) frame_err = 1;
        last_sfall = cyc; bidx--;
        sdo_i = (bidx >= 0) ? a_res[bidx] : 1'b0;
      end
      if (want_low) begin
        check(!res_valid_o, "R7 strobe one cycle", res_valid_o, 0);
        want_low = 0;
      end
      if (res_valid_o) begin
        int exp_v, act_v;
        exp_v = a_bip ? int'(signed'(a_res)) : int'(a_res);
        act_v = int'(signed'(res_value_o));
        check(cyc - last_rise == LAT, "R7 result latency", cyc - last_rise, LAT);
        check(res_data_o == a_res, "R6 result bits", res_data_o, a_res);
        check(act_v == exp_v, "R8 extended value", act_v, exp_v);
        check(res_cfg_o == a_cfg, "R8 R10 config echo", res_cfg_o, a_cfg);
        check(cap == {a_cfg, 2'b00}, "R5 config on data line", cap, {a_cfg, 2'b00});
        check(sck_rises == NB && !frame_err, "R4 clock shape", sck_rises, NB);
        check(!cnv_sck_err, "R3 clock idle in conversion", cnv_sck_err, 0);
        valid_cnt++; last_valid = cyc; have_valid = 1; want_low = 1;
      end
    end
    p_cnv = cnv_o;
    p_sck = sck_o;
  end

  always @(posedge clk) begin
    if (cyc > WDOG && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WDOG);
      summary();
    end
  end

  task automatic do_req(input logic [13:0] c, input logic b, input logic [15:0] r);
    @(negedge clk);
    start_i = 1'b1; cfg_i = c; bipolar_i = b;
    if (!m_pend) m_first_req = cyc;
    m_pend = 1; m_cfg = c; m_bip = b; m_res = r;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_valid(input int n);
    while (valid_cnt < n) @(negedge clk);
  endtask

  task automatic wait_rise(input int n);
    while (rise_cnt < n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; cfg_i = '0; bipolar_i = 1'b0; sdo_i = 1'b0;
    repeat (4) @(negedge clk);
    check({cnv_o, sck_o, sdi_o, res_valid_o} == 4'b0, "R1 outputs in reset",
          {cnv_o, sck_o, sdi_o, res_valid_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({cnv_o, sck_o, sdi_o, res_valid_o} == 4'b0, "R1 outputs after reset",
          {cnv_o, sck_o, sdi_o, res_valid_o}, 0);

    // Idle launch, unipolar
    do_req(14'h2A5C, 1'b0, 16'hBEEF);
    wait_valid(1);
    repeat (150) @(negedge clk);
    // Bipolar, most negative region
    do_req(14'h1234, 1'b1, 16'h8001);
    wait_valid(2);
    repeat (130) @(negedge clk);
    // Bipolar max positive, then a request held by the running conversion
    do_req(14'h3FFF, 1'b1, 16'h7FFF);
    wait_rise(3);
    repeat (10) @(negedge clk);
    do_req(14'h0001, 1'b0, 16'hFFFF);
    wait_valid(4);
    // Request while idle but spacing not yet met
    repeat (5) @(negedge clk);
    do_req(14'h2000, 1'b1, 16'h0000);
    wait_valid(5);
    repeat (130) @(negedge clk);
    // R10: two requests held during one conversion merge into a single launch
    do_req(14'h0AAA, 1'b0, 16'h1111);
    wait_rise(6);
    repeat (5) @(negedge clk);
    do_req(14'h2BCD, 1'b0, 16'hA5A5);
    repeat (10) @(negedge clk);
    do_req(14'h1555, 1'b1, 16'hC3C3);
    wait_valid(7);
    repeat (250) @(negedge clk);
    check(rise_cnt == 7, "R10 single merged conversion", rise_cnt, 7);
    check(!cnv_o && !sck_o, "R10 no further activity", {cnv_o, sck_o}, 0);
    summary();
  end

endmodule